// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the control state machine that moves a processor core into and out of exception handlers. An external arbiter presents the winning exception number and its group priority. The sequencer then orders three abstract memory phases. It saves state with a push phase, loads a handler address with a vector-fetch phase, and restores context with a pop phase. Each phase is a level request that holds until its done strobe. The core reports two events: when the first handler instruction reaches execute, and when the handler completes.

A four-level stack holds the priority and number of each active handler. The top entry sets the preemption threshold. A lower numeric priority value is more urgent. A request preempts the running handler only if its value is strictly lower than the value on top of the stack. Two shortcuts skip memory work. Tail-chaining goes straight from one completed handler to the next vector fetch with no pop and no push. A late arrival changes the fetch target while the state save carries on. A handler is recorded as active only once its first instruction executes. Until then, a more urgent request may still take its place.

Top module: `exc_seq`

## Requirements
- R1: During and after reset, `push_req`, `pop_req` and `fetch_req` are low, `act_valid` is low and `act_depth` is 0.
- R2: In thread mode (`act_depth` 0, no phase in progress), a `req_valid` sampled at a clock edge raises `push_req` after that edge. The `push_done` edge lowers `push_req` and raises `fetch_req` with `fetch_num` equal to the target number.
- R3: While `push_req` is high, a request whose priority value is strictly lower than the target's replaces the target, and `push_req` stays high without a break. A request of equal or higher value leaves the target unchanged.
- R4: Between the start of a vector fetch and the first handler instruction, a request with a strictly lower priority value than the target replaces it. If the fetch had already finished, a new fetch starts for the new number and no push occurs.
- R5: A `first_exec` pulse after a completed fetch makes that handler active. One edge later `act_depth` has risen by 1, `act_valid` is 1, and `act_num` is the handler's number.
- R6: While a handler is active, a request preempts it (raises `push_req`) only if its priority value is strictly lower than the active handler's. Requests of equal or higher value raise no phase request.
- R7: With four handlers active, no request starts a preemption, and `act_depth` never exceeds 4.
- R8: When `hdl_done` arrives with a request that beats the level restored beneath the completing handler (any request if none remains), `fetch_req` rises after that edge. `pop_req` stays low, and `act_depth` drops by 1.
- R9: When `hdl_done` arrives with no eligible request, `pop_req` rises and `act_depth` drops by 1. On `pop_done` the sequencer returns to thread mode if the stack is empty; otherwise it resumes the previous handler, whose number shows on `act_num`.
- R10: While `pop_req` is high, a request that beats the restored level aborts the pop. `pop_req` falls and `fetch_req` rises on the next edge, with `fetch_num` equal to the request number.
- R11: At most one of `push_req`, `pop_req`, `fetch_req` is high at a time. Each stays high until its done strobe, except that a pop can be aborted as in R10.
- R12: `hdl_done` before a handler's first instruction has executed is ignored. `first_exec` in thread mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Arbiter presents a pending exception |
| req_num | input | NUM_W | Number of the pending exception |
| req_prio | input | PRIO_W | Group priority, lower value more urgent |
| hdl_done | input | 1 | Current handler has completed |
| first_exec | input | 1 | First handler instruction has reached execute |
| push_req | output | 1 | State-save phase request |
| push_done | input | 1 | State save finished |
| fetch_req | output | 1 | Vector-fetch phase request |
| fetch_num | output | NUM_W | Exception number whose vector is fetched |
| fetch_done | input | 1 | Vector fetch finished |
| pop_req | output | 1 | Context-restore phase request |
| pop_done | input | 1 | Context restore finished |
| act_valid | output | 1 | At least one handler is active |
| act_num | output | NUM_W | Number of the innermost active handler |
| act_depth | output | $clog2(DEPTH+1) | Count of active handlers |

## Verification
A corrupted stack entry or count shows up as a wrong `act_num` or `act_depth`. This is visible one edge after the `first_exec` or `hdl_done` that touches it. Otherwise it appears when the next return resumes the wrong handler. A wrong state or target shows up at the next phase boundary. Symptoms are a missing or extra `push_req`/`pop_req`, or a `fetch_num` different from the latest eligible request, seen the cycle after the triggering strobe. The tests therefore sample every phase request and the active-handler outputs one edge after each stimulus. They also unwind every nesting level to compare each resumed number.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int unsigned NUM_W_DEF  = 6;
    localparam int unsigned PRIO_W_DEF = 3;
    localparam int unsigned DEPTH_DEF  = 4;

    typedef enum logic [2:0] {
        ST_THREAD,
        ST_STACKING,
        ST_VECFETCH,
        ST_HANDLER,
        ST_UNSTACKING
    } seq_state_e;

    // lower value is the more urgent priority
    function automatic logic outranks(input logic [7:0] cand, input logic [7:0] ref_lvl);
        return cand < ref_lvl;
    endfunction

endpackage

// File: rtl/exc_stack.sv
module exc_stack #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned NUM_W  = 6,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [NUM_W-1:0]  push_num,
    output logic [CNT_W-1:0]  cnt,
    output logic [PRIO_W-1:0] top_prio,
    output logic [NUM_W-1:0]  top_num,
    output logic [PRIO_W-1:0] below_prio,
    output logic              full
);

    logic [PRIO_W-1:0] prio_q [DEPTH];
    logic [NUM_W-1:0]  num_q  [DEPTH];

    assign full = (cnt == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                prio_q[i] <= '0;
                num_q[i]  <= '0;
            end
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cnt == CNT_W'(i)) begin
                    prio_q[i] <= push_prio;
                    num_q[i]  <= push_num;
                end
            end
            cnt <= cnt + 1'b1;
        end else if (pop && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // top entry and the one beneath it
    always_comb begin
        top_prio   = '0;
        top_num    = '0;
        below_prio = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CNT_W'(i + 1)) begin
                top_prio = prio_q[i];
                top_num  = num_q[i];
            end
            if (cnt == CNT_W'(i + 2)) begin
                below_prio = prio_q[i];
            end
        end
    end

endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_seq_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned NUM_W  = 6,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [NUM_W-1:0]  req_num,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              hdl_done,
    input  logic              first_exec,
    input  logic              push_done,
    input  logic              pop_done,
    input  logic              fetch_done,
    input  logic [CNT_W-1:0]  stk_cnt,
    input  logic [PRIO_W-1:0] stk_top_prio,
    input  logic [PRIO_W-1:0] stk_below_prio,
    input  logic              stk_full,
    output logic              push_req,
    output logic              pop_req,
    output logic              fetch_req,
    output logic [NUM_W-1:0]  fetch_num,
    output logic              stk_push,
    output logic              stk_pop,
    output logic [PRIO_W-1:0] stk_push_prio,
    output logic [NUM_W-1:0]  stk_push_num
);

    seq_state_e        state_q, state_d;
    logic [NUM_W-1:0]  tgt_num_q;
    logic [PRIO_W-1:0] tgt_prio_q;
    logic              started_q, started_d;
    logic              take;

    logic empty, beats_top, may_preempt, may_chain, late;

    assign empty       = (stk_cnt == '0);
    assign beats_top   = empty || outranks(8'(req_prio), 8'(stk_top_prio));
    assign may_preempt = req_valid && !stk_full && beats_top;
    assign may_chain   = req_valid && ((stk_cnt == CNT_W'(1)) ||
                                       outranks(8'(req_prio), 8'(stk_below_prio)));
    assign late        = req_valid && outranks(8'(req_prio), 8'(tgt_prio_q));

    always_comb begin
        state_d   = state_q;
        started_d = started_q;
        take      = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        case (state_q)
            ST_THREAD: begin
                if (req_valid) begin
                    take    = 1'b1;
                    state_d = ST_STACKING;
                end
            end
            ST_STACKING: begin
                take = late;
                if (push_done) state_d = ST_VECFETCH;
            end
            ST_VECFETCH: begin
                if (fetch_done) begin
                    state_d   = ST_HANDLER;
                    started_d = 1'b0;
                end else begin
                    take = late;
                end
            end
            ST_HANDLER: begin
                if (!started_q) begin
                    if (first_exec) begin
                        stk_push  = 1'b1;
                        started_d = 1'b1;
                    end else if (late) begin
                        take    = 1'b1;
                        state_d = ST_VECFETCH;
                    end
                end else if (hdl_done) begin
                    stk_pop = 1'b1;
                    if (may_chain) begin
                        take    = 1'b1;
                        state_d = ST_VECFETCH;
                    end else begin
                        state_d = ST_UNSTACKING;
                    end
                end else if (may_preempt) begin
                    take    = 1'b1;
                    state_d = ST_STACKING;
                end
            end
            ST_UNSTACKING: begin
                if (req_valid && beats_top) begin
                    take    = 1'b1;
                    state_d = ST_VECFETCH;
                end else if (pop_done) begin
                    state_d   = empty ? ST_THREAD : ST_HANDLER;
                    started_d = 1'b1;
                end
            end
            default: state_d = ST_THREAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_THREAD;
            started_q  <= 1'b0;
            tgt_num_q  <= '0;
            tgt_prio_q <= '0;
        end else begin
            state_q   <= state_d;
            started_q <= started_d;
            if (take) begin
                tgt_num_q  <= req_num;
                tgt_prio_q <= req_prio;
            end
        end
    end

    assign push_req      = (state_q == ST_STACKING);
    assign pop_req       = (state_q == ST_UNSTACKING);
    assign fetch_req     = (state_q == ST_VECFETCH);
    assign fetch_num     = tgt_num_q;
    assign stk_push_prio = tgt_prio_q;
    assign stk_push_num  = tgt_num_q;

endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int unsigned DEPTH  = DEPTH_DEF,
    parameter int unsigned NUM_W  = NUM_W_DEF,
    parameter int unsigned PRIO_W = PRIO_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [NUM_W-1:0]           req_num,
    input  logic [PRIO_W-1:0]          req_prio,
    input  logic                       hdl_done,
    input  logic                       first_exec,
    output logic                       push_req,
    input  logic                       push_done,
    output logic                       fetch_req,
    output logic [NUM_W-1:0]           fetch_num,
    input  logic                       fetch_done,
    output logic                       pop_req,
    input  logic                       pop_done,
    output logic                       act_valid,
    output logic [NUM_W-1:0]           act_num,
    output logic [$clog2(DEPTH+1)-1:0] act_depth
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic              stk_push, stk_pop, stk_full;
    logic [PRIO_W-1:0] stk_push_prio, stk_top_prio, stk_below_prio;
    logic [NUM_W-1:0]  stk_push_num;
    logic [CNT_W-1:0]  stk_cnt;

    exc_fsm #(.DEPTH(DEPTH), .NUM_W(NUM_W), .PRIO_W(PRIO_W)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_num        (req_num),
        .req_prio       (req_prio),
        .hdl_done       (hdl_done),
        .first_exec     (first_exec),
        .push_done      (push_done),
        .pop_done       (pop_done),
        .fetch_done     (fetch_done),
        .stk_cnt        (stk_cnt),
        .stk_top_prio   (stk_top_prio),
        .stk_below_prio (stk_below_prio),
        .stk_full       (stk_full),
        .push_req       (push_req),
        .pop_req        (pop_req),
        .fetch_req      (fetch_req),
        .fetch_num      (fetch_num),
        .stk_push       (stk_push),
        .stk_pop        (stk_pop),
        .stk_push_prio  (stk_push_prio),
        .stk_push_num   (stk_push_num)
    );

    exc_stack #(.DEPTH(DEPTH), .NUM_W(NUM_W), .PRIO_W(PRIO_W)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (stk_push),
        .pop        (stk_pop),
        .push_prio  (stk_push_prio),
        .push_num   (stk_push_num),
        .cnt        (stk_cnt),
        .top_prio   (stk_top_prio),
        .top_num    (act_num),
        .below_prio (stk_below_prio),
        .full       (stk_full)
    );

    assign act_depth = stk_cnt;
    assign act_valid = (stk_cnt != '0);

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             push_req,
    input logic             push_done,
    input logic             pop_req,
    input logic             pop_done,
    input logic             fetch_req,
    input logic             fetch_done,
    input logic [CNT_W-1:0] act_depth
);

    p_phase_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push_req, pop_req, fetch_req}));

    p_push_hold_r11: assert property (@(posedge clk) disable iff (rst)
        push_req && !push_done |=> push_req);

    p_fetch_hold_r11: assert property (@(posedge clk) disable iff (rst)
        fetch_req && !fetch_done |=> fetch_req);

    p_pop_hold_r10: assert property (@(posedge clk) disable iff (rst)
        pop_req && !pop_done && !req_valid |=> pop_req);

    p_push_to_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        push_req && push_done |=> fetch_req && !push_req);

    p_pop_keeps_depth_r9: assert property (@(posedge clk) disable iff (rst)
        pop_req && pop_done && !req_valid |=> !pop_req && act_depth == $past(act_depth));

    p_depth_max_r7: assert property (@(posedge clk) disable iff (rst)
        act_depth <= CNT_W'(DEPTH));

    p_depth_step_r5: assert property (@(posedge clk) disable iff (rst)
        act_depth != $past(act_depth) |->
            (act_depth == $past(act_depth) + 1'b1) || (act_depth == $past(act_depth) - 1'b1));

endmodule

bind exc_seq exc_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .push_req   (push_req),
    .push_done  (push_done),
    .pop_req    (pop_req),
    .pop_done   (pop_done),
    .fetch_req  (fetch_req),
    .fetch_done (fetch_done),
    .act_depth  (act_depth)
);

// File: tb/sim_exc_seq.sv
`timescale 1ns/1ps
module sim_exc_seq;

    localparam int NUM_W  = 6;
    localparam int PRIO_W = 3;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [NUM_W-1:0]  req_num = '0;
    logic [PRIO_W-1:0] req_prio = '0;
    logic hdl_done = 1'b0, first_exec = 1'b0;
    logic push_done = 1'b0, fetch_done = 1'b0, pop_done = 1'b0;
    logic push_req, fetch_req, pop_req, act_valid;
    logic [NUM_W-1:0] fetch_num, act_num;
    logic [CNT_W-1:0] act_depth;

    int n_chk = 0;
    int n_fail = 0;
    int exp_depth = 0;
    int m_num [DEPTH];

    always #5 clk = ~clk;

    exc_seq #(.DEPTH(DEPTH), .NUM_W(NUM_W), .PRIO_W(PRIO_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_num(req_num),
        .req_prio(req_prio), .hdl_done(hdl_done), .first_exec(first_exec),
        .push_req(push_req), .push_done(push_done), .fetch_req(fetch_req),
        .fetch_num(fetch_num), .fetch_done(fetch_done), .pop_req(pop_req),
        .pop_done(pop_done), .act_valid(act_valid), .act_num(act_num),
        .act_depth(act_depth)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic request(input int num, input int prio);
        req_valid = 1'b1;
        req_num   = NUM_W'(num);
        req_prio  = PRIO_W'(prio);
    endtask

    task automatic drop_req();
        req_valid = 1'b0;
    endtask

    // finish a fetch for num and run its first instruction
    task automatic fetch_and_start(input int num);
        int w;
        w = int'($urandom % 3);
        for (int i = 0; i < w; i++) begin
            cyc();
            chk("R11 fetch_req held", fetch_req, 1);
        end
        fetch_done = 1'b1;
        cyc();
        fetch_done = 1'b0;
        chk("R11 fetch_req dropped", fetch_req, 0);
        first_exec = 1'b1;
        cyc();
        first_exec = 1'b0;
        m_num[exp_depth] = num;
        exp_depth++;
        chk("R5 act_depth", act_depth, exp_depth);
        chk("R5 act_valid", act_valid, 1);
        chk("R5 act_num", act_num, num);
    endtask

    // full entry from thread or by preemption
    task automatic enter(input int num, input int prio);
        int w;
        request(num, prio);
        cyc();
        drop_req();
        chk("R2/R6 push_req", push_req, 1);
        w = int'($urandom % 4);
        for (int i = 0; i < w; i++) begin
            cyc();
            chk("R11 push_req held", push_req, 1);
        end
        push_done = 1'b1;
        cyc();
        push_done = 1'b0;
        chk("R2 fetch_req", fetch_req, 1);
        chk("R2 fetch_num", fetch_num, num);
        fetch_and_start(num);
    endtask

    // completion with nothing pending: full return
    task automatic leave();
        int w;
        hdl_done = 1'b1;
        cyc();
        hdl_done = 1'b0;
        exp_depth--;
        chk("R9 pop_req", pop_req, 1);
        chk("R9 depth after done", act_depth, exp_depth);
        w = int'($urandom % 3);
        for (int i = 0; i < w; i++) begin
            cyc();
            chk("R11 pop_req held", pop_req, 1);
        end
        pop_done = 1'b1;
        cyc();
        pop_done = 1'b0;
        chk("R9 pop_req dropped", pop_req, 0);
        chk("R9 act_valid", act_valid, exp_depth != 0);
        if (exp_depth != 0) chk("R9 resumed act_num", act_num, m_num[exp_depth-1]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) cyc();
        chk("R1 push_req in reset", push_req, 0);
        chk("R1 fetch_req in reset", fetch_req, 0);
        chk("R1 pop_req in reset", pop_req, 0);
        rst = 1'b0;
        cyc();
        chk("R1 act_valid", act_valid, 0);
        chk("R1 act_depth", act_depth, 0);

        // R12: first_exec ignored in thread mode
        first_exec = 1'b1;
        cyc();
        first_exec = 1'b0;
        cyc();
        chk("R12 first_exec in thread depth", act_depth, 0);
        chk("R12 first_exec in thread fetch", fetch_req, 0);

        // nesting, ignored requests, returns
        enter(5, 4);
        enter(7, 2);
        request(20, 2);
        cyc(); cyc();
        chk("R6 equal prio no push", push_req, 0);
        request(21, 5);
        cyc(); cyc();
        drop_req();
        chk("R6 lower urgency no push", push_req, 0);
        chk("R6 act_num kept", act_num, 7);
        leave();
        leave();
        chk("R9 back to thread", act_depth, 0);

        // tail chain from the last handler
        enter(3, 3);
        hdl_done = 1'b1;
        request(9, 6);
        cyc();
        hdl_done = 1'b0;
        drop_req();
        exp_depth--;
        chk("R8 tail fetch_req", fetch_req, 1);
        chk("R8 no pop_req", pop_req, 0);
        chk("R8 fetch_num", fetch_num, 9);
        chk("R8 depth", act_depth, 0);
        fetch_and_start(9);
        leave();

        // tail chain gated by the restored level
        enter(1, 5);
        enter(2, 3);
        hdl_done = 1'b1;
        request(30, 6);
        cyc();
        hdl_done = 1'b0;
        chk("R9 not eligible pops", pop_req, 1);
        chk("R8 not eligible no fetch", fetch_req, 0);
        drop_req();
        exp_depth--;
        pop_done = 1'b1;
        cyc();
        pop_done = 1'b0;
        chk("R9 resume act_num", act_num, 1);
        leave();

        // late arrivals
        request(4, 6);
        cyc();
        chk("R2 push_req", push_req, 1);
        request(11, 4);
        cyc();
        chk("R3 push_req unbroken", push_req, 1);
        request(12, 4);
        cyc();
        chk("R3 push_req unbroken equal", push_req, 1);
        drop_req();
        push_done = 1'b1;
        cyc();
        push_done = 1'b0;
        chk("R3 late target fetch_num", fetch_num, 11);
        request(13, 3);
        cyc();
        drop_req();
        chk("R4 fetch retarget", fetch_num, 13);
        chk("R4 fetch_req", fetch_req, 1);
        fetch_done = 1'b1;
        cyc();
        fetch_done = 1'b0;
        hdl_done = 1'b1;
        cyc();
        hdl_done = 1'b0;
        chk("R12 early hdl_done no pop", pop_req, 0);
        chk("R12 early hdl_done depth", act_depth, 0);
        request(14, 1);
        cyc();
        drop_req();
        chk("R4 refetch after fetch", fetch_req, 1);
        chk("R4 refetch no push", push_req, 0);
        chk("R4 refetch num", fetch_num, 14);
        fetch_and_start(14);
        // original chains in after the late handler
        hdl_done = 1'b1;
        request(13, 3);
        cyc();
        hdl_done = 1'b0;
        drop_req();
        exp_depth--;
        chk("R8 original chains in", fetch_num, 13);
        chk("R8 chain no pop", pop_req, 0);
        fetch_and_start(13);
        leave();

        // aborted pop
        enter(2, 5);
        hdl_done = 1'b1;
        cyc();
        hdl_done = 1'b0;
        exp_depth--;
        chk("R9 pop_req", pop_req, 1);
        request(8, 6);
        cyc();
        drop_req();
        chk("R10 pop aborted", pop_req, 0);
        chk("R10 fetch_req", fetch_req, 1);
        chk("R10 fetch_num", fetch_num, 8);
        fetch_and_start(8);
        leave();

        // depth limit
        enter(40, 6);
        enter(41, 5);
        enter(42, 4);
        enter(43, 3);
        chk("R7 depth full", act_depth, 4);
        request(44, 0);
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R7 no preempt when full", push_req, 0);
        end
        drop_req();
        for (int i = 0; i < 4; i++) leave();
        chk("R7 unwound", act_depth, 0);

        // random nests with random latencies
        for (int it = 0; it < 40; it++) begin
            int k;
            int p;
            k = 1 + int'($urandom % 4);
            p = (k - 1) + int'($urandom % (9 - k));
            for (int lv = 0; lv < k; lv++) begin
                enter(int'($urandom % 64), p);
                p = p - 1 - int'($urandom % 2);
                if (p < 0) break;
            end
            while (exp_depth > 0) leave();
            chk("R9 random unwind depth", act_depth, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule